// File: doc/BRIEF.md
# Four-Way Vector Unzip Unit

This block is a permutation datapath for a vector pipeline. It receives one 32-bit instruction word together with the contents of four consecutive source vectors, each VL bits wide. Every source is cut into groups of four elements. Element k of each group is gathered into destination vector k, and the gathered elements keep their source order. The element width is chosen at run time from 8, 16, 32, 64 or 128 bits.

A small decoder checks the fixed bits of the instruction word and extracts the element width and the first register of the source and destination groups. It raises an undefined flag for encodings it does not recognise, for element widths the configured maximum vector length cannot carry, and for widths that do not fit four times into VL. The unit has a fixed one-cycle latency that does not depend on the data. On an undefined instruction it still pulses done so that the issuing logic can trap, and it leaves the result vectors unchanged.

Top module: `vec_unzip4`

## Requirements
- R1: In the narrow class (bits 21:16 = 110110), the element width is 8 shifted left by the size field in bits 23:22, so 00, 01, 10 and 11 give 8, 16, 32 and 64 bits.
- R2: In the wide class (bits 21:16 = 110111 with bits 23:22 = 00), the element width is 128 bits.
- R3: With Q = VL / (4 * width), the element at position r*Q+q of destination k equals element 4q+k of source r, for r and k from 0 to 3 and q from 0 to Q-1. Element e occupies bits e*width upward.
- R4: src_base equals bits 9:7 times four, and dst_base equals bits 4:2 times four.
- R5: The word is undefined unless bits 31:24 = 0xC1, bits 15:10 = 111000, bits 6:5 = 00, bits 1:0 = 10, and one of the class patterns of R1 or R2 matches.
- R6: A 64-bit width is undefined when MAX_VL is below 256. The wide class is undefined when MAX_VL is below 512.
- R7: The word is undefined when VL is smaller than four times the element width.
- R8: done is high exactly in the cycle after a cycle with in_valid high. Results, bases and the undefined flag update at that same edge.
- R9: When an accepted word is undefined, undef reads 1 and done still pulses, and res0 to res3 keep their previous values.
- R10: While in_valid is low, the results do not change, whatever the source inputs do.
- R11: After reset, the results and bases are zero and done and undef are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| src0 | input | VL | First source vector of the group |
| src1 | input | VL | Second source vector |
| src2 | input | VL | Third source vector |
| src3 | input | VL | Fourth source vector |
| res0 | output | VL | Destination vector 0 (element 0 of each group) |
| res1 | output | VL | Destination vector 1 |
| res2 | output | VL | Destination vector 2 |
| res3 | output | VL | Destination vector 3 |
| src_base | output | 5 | First source register index of the group |
| dst_base | output | 5 | First destination register index of the group |
| undef | output | 1 | Last accepted word was undefined |
| done | output | 1 | Result strobe, one cycle after in_valid |

## Verification
The completion strobe and the undefined-instruction hold can fall in the same cycle. This happens when a legal word is followed directly by an illegal one. The bench issues these two words back to back with no idle cycle between them, so done stays high across both edges. At the second edge undef must rise, and the four results must still hold the permutation of the first word. Two legal words back to back are judged the same way: the results must switch to the second permutation at the second edge, with done never falling.

// File: rtl/vec_unzip4_pkg.sv
package vec_unzip4_pkg;

  localparam int GROUP   = 4;
  localparam int NUM_ESZ = 5;

  typedef enum logic [2:0] {
    ESZ_8   = 3'd0,
    ESZ_16  = 3'd1,
    ESZ_32  = 3'd2,
    ESZ_64  = 3'd3,
    ESZ_128 = 3'd4
  } esz_e;

  function automatic int esz_bits(input esz_e code);
    return 8 << int'(code);
  endfunction

  function automatic int group_count(input int vl, input int width);
    return vl / (GROUP * width);
  endfunction

  function automatic logic [4:0] group_first(input logic [2:0] field);
    return {field, 2'b00};
  endfunction

endpackage

// File: rtl/vec_unzip4_decode.sv
module vec_unzip4_decode
  import vec_unzip4_pkg::*;
#(
  parameter int VL     = 512,
  parameter int MAX_VL = 512
) (
  input  logic [31:0] instr,
  output esz_e        esz,
  output logic [4:0]  src_first,
  output logic [4:0]  dst_first,
  output logic        is_undef
);

  localparam bit CAP_D = (MAX_VL >= 256);
  localparam bit CAP_Q = (MAX_VL >= 512);

  logic shell_ok, narrow_hit, wide_hit, enc_ok, cap_ok, fit_ok;
  logic [NUM_ESZ-1:0] fit_vec;

  for (genvar g = 0; g < NUM_ESZ; g++) begin : g_fit
    assign fit_vec[g] = (VL >= (GROUP * (8 << g)));
  end

  assign shell_ok   = (instr[31:24] == 8'hC1) && (instr[15:10] == 6'b111000) &&
                      (instr[6:5] == 2'b00) && (instr[1:0] == 2'b10);
  assign narrow_hit = (instr[21:16] == 6'b110110);
  assign wide_hit   = (instr[21:16] == 6'b110111) && (instr[23:22] == 2'b00);
  assign enc_ok     = shell_ok && (narrow_hit || wide_hit);

  assign esz       = wide_hit ? ESZ_128 : esz_e'({1'b0, instr[23:22]});
  assign src_first = group_first(instr[9:7]);
  assign dst_first = group_first(instr[4:2]);

  always_comb begin
    case (esz)
      ESZ_64:  cap_ok = CAP_D;
      ESZ_128: cap_ok = CAP_Q;
      default: cap_ok = 1'b1;
    endcase
    case (esz)
      ESZ_8:   fit_ok = fit_vec[0];
      ESZ_16:  fit_ok = fit_vec[1];
      ESZ_32:  fit_ok = fit_vec[2];
      ESZ_64:  fit_ok = fit_vec[3];
      ESZ_128: fit_ok = fit_vec[4];
      default: fit_ok = 1'b0;
    endcase
  end

  assign is_undef = !(enc_ok && cap_ok && fit_ok);

  // R7 / R6: a word reported legal must fit VL and the capability limit
  always_comb begin
    if (!is_undef) begin
      p_fit_r7: assert (VL >= GROUP * esz_bits(esz));
      p_cap_r6: assert (!(esz == ESZ_128) || MAX_VL >= 512);
    end
  end

endmodule

// File: rtl/vec_unzip4_perm.sv
module vec_unzip4_perm
  import vec_unzip4_pkg::*;
#(
  parameter int VL = 512
) (
  input  logic [GROUP-1:0][VL-1:0] src,
  input  esz_e                     esz,
  output logic [GROUP-1:0][VL-1:0] dst
);

  logic [NUM_ESZ-1:0][GROUP-1:0][VL-1:0] cand;

  for (genvar g = 0; g < NUM_ESZ; g++) begin : g_size
    localparam int ES = 8 << g;
    if (VL >= GROUP * ES) begin : g_legal
      localparam int Q = VL / (GROUP * ES);
      for (genvar r = 0; r < GROUP; r++) begin : g_src
        for (genvar q = 0; q < Q; q++) begin : g_grp
          for (genvar k = 0; k < GROUP; k++) begin : g_lane
            assign cand[g][k][(r*Q+q)*ES +: ES] = src[r][(GROUP*q+k)*ES +: ES];
          end
        end
      end
    end else begin : g_none
      assign cand[g] = '0;
    end
  end

  always_comb begin
    case (esz)
      ESZ_8:   dst = cand[0];
      ESZ_16:  dst = cand[1];
      ESZ_32:  dst = cand[2];
      ESZ_64:  dst = cand[3];
      ESZ_128: dst = cand[4];
      default: dst = '0;
    endcase
  end

endmodule

// File: rtl/vec_unzip4.sv
module vec_unzip4
  import vec_unzip4_pkg::*;
#(
  parameter int VL     = 512,
  parameter int MAX_VL = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [31:0]   instr,
  input  logic [VL-1:0] src0,
  input  logic [VL-1:0] src1,
  input  logic [VL-1:0] src2,
  input  logic [VL-1:0] src3,
  output logic [VL-1:0] res0,
  output logic [VL-1:0] res1,
  output logic [VL-1:0] res2,
  output logic [VL-1:0] res3,
  output logic [4:0]    src_base,
  output logic [4:0]    dst_base,
  output logic          undef,
  output logic          done
);

  esz_e                     dec_esz;
  logic [4:0]               dec_src, dec_dst;
  logic                     dec_undef;
  logic [GROUP-1:0][VL-1:0] src_bus, dst_bus;
  logic                     take, trap;
  logic [7:0]               peek1;

  assign src_bus = {src3, src2, src1, src0};

  vec_unzip4_decode #(.VL(VL), .MAX_VL(MAX_VL)) i_dec (
    .instr     (instr),
    .esz       (dec_esz),
    .src_first (dec_src),
    .dst_first (dec_dst),
    .is_undef  (dec_undef)
  );

  vec_unzip4_perm #(.VL(VL)) i_perm (
    .src (src_bus),
    .esz (dec_esz),
    .dst (dst_bus)
  );

  assign take  = in_valid && !dec_undef;
  assign trap  = in_valid && dec_undef;
  assign peek1 = 8'(src0 >> (32'd8 << dec_esz));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res0     <= '0;
      res1     <= '0;
      res2     <= '0;
      res3     <= '0;
      src_base <= '0;
      dst_base <= '0;
      undef    <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= in_valid;
      if (in_valid) begin
        undef    <= dec_undef;
        src_base <= dec_src;
        dst_base <= dec_dst;
      end
      if (take) begin
        res0 <= dst_bus[0];
        res1 <= dst_bus[1];
        res2 <= dst_bus[2];
        res3 <= dst_bus[3];
      end
    end
  end

  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> done);
  p_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !done);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> (undef && $stable(res0) && $stable(res1) && $stable(res2) && $stable(res3)));
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(res0) && $stable(res1) && $stable(res2) && $stable(res3)));
  p_first_elem_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (res1[7:0] == $past(peek1)));

endmodule

// File: tb/test_vec_unzip4.sv
module test_vec_unzip4;

  localparam int VA = 512;
  localparam int VB = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [3:0][VA-1:0] srcs = '0;

  logic [VA-1:0] a0, a1, a2, a3;
  logic [VB-1:0] b0, b1, b2, b3;
  logic [4:0] a_sb, a_db, b_sb, b_db;
  logic a_undef, a_done, b_undef, b_done;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  vec_unzip4 #(.VL(VA), .MAX_VL(VA)) i_vec_unzip4 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .src0(srcs[0]), .src1(srcs[1]), .src2(srcs[2]), .src3(srcs[3]),
    .res0(a0), .res1(a1), .res2(a2), .res3(a3),
    .src_base(a_sb), .dst_base(a_db), .undef(a_undef), .done(a_done)
  );

  vec_unzip4 #(.VL(VB), .MAX_VL(VB)) i_vec_unzip4_small (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .src0(srcs[0][VB-1:0]), .src1(srcs[1][VB-1:0]),
    .src2(srcs[2][VB-1:0]), .src3(srcs[3][VB-1:0]),
    .res0(b0), .res1(b1), .res2(b2), .res3(b3),
    .src_base(b_sb), .dst_base(b_db), .undef(b_undef), .done(b_done)
  );

  task automatic chk(input string req, input string what,
                     input logic [VA-1:0] act, input logic [VA-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] w_narrow(input logic [1:0] sz, input logic [2:0] zn,
                                           input logic [2:0] zd);
    return {8'hC1, sz, 6'b110110, 6'b111000, zn, 2'b00, zd, 2'b10};
  endfunction

  function automatic logic [31:0] w_wide(input logic [2:0] zn, input logic [2:0] zd);
    return {8'hC1, 2'b00, 6'b110111, 6'b111000, zn, 2'b00, zd, 2'b10};
  endfunction

  function automatic logic [3:0][VA-1:0] fill(input int seed);
    logic [3:0][VA-1:0] s;
    for (int r = 0; r < 4; r++)
      for (int b = 0; b < VA/8; b++)
        s[r][b*8 +: 8] = 8'((r*VA/8 + b) * 13 + seed * 29 + (b >> 3));
    return s;
  endfunction

  // Walks destination positions and looks up where each one comes from.
  function automatic logic [VA-1:0] expect_vec(input logic [3:0][VA-1:0] s, input int k,
                                               input int es, input int vl);
    logic [VA-1:0] o = '0;
    int groups = vl / (4 * es);
    for (int p = 0; p < vl / es; p++) begin
      int r = p / groups;
      int q = p % groups;
      for (int b = 0; b < es; b++) o[p*es + b] = s[r][(4*q + k)*es + b];
    end
    return o;
  endfunction

  task automatic issue(input logic [31:0] w, input logic [3:0][VA-1:0] s);
    @(negedge clk);
    instr = w;
    srcs = s;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_a(input string req, input logic [3:0][VA-1:0] s, input int es);
    chk(req, "res0", a0, expect_vec(s, 0, es, VA));
    chk(req, "res1", a1, expect_vec(s, 1, es, VA));
    chk(req, "res2", a2, expect_vec(s, 2, es, VA));
    chk(req, "res3", a3, expect_vec(s, 3, es, VA));
  endtask

  task automatic t_reset();
    chk("R11", "res0 after reset", a0, '0);
    chk("R11", "res3 after reset", a3, '0);
    chk("R11", "bases after reset", VA'({a_sb, a_db}), '0);
    chk("R11", "done/undef after reset", VA'({a_done, a_undef}), '0);
  endtask

  task automatic t_sizes();
    for (int sz = 0; sz < 4; sz++) begin
      logic [3:0][VA-1:0] s = fill(sz + 1);
      issue(w_narrow(2'(sz), 3'd1, 3'd2), s);
      check_a("R1 R3", s, 8 << sz);
      chk("R5", "undef on legal narrow", VA'(a_undef), '0);
      chk("R8", "done after valid", VA'(a_done), 1);
      @(negedge clk);
      chk("R8", "done single pulse", VA'(a_done), 0);
    end
    begin
      logic [3:0][VA-1:0] s = fill(9);
      issue(w_wide(3'd3, 3'd6), s);
      check_a("R2 R3", s, 128);
      chk("R2", "undef on legal wide", VA'(a_undef), '0);
    end
  endtask

  task automatic t_bases();
    issue(w_narrow(2'd0, 3'd7, 3'd5), fill(4));
    chk("R4", "src_base zn=7", VA'(a_sb), 28);
    chk("R4", "dst_base zd=5", VA'(a_db), 20);
    issue(w_narrow(2'd2, 3'd0, 3'd0), fill(5));
    chk("R4", "bases zero", VA'({a_sb, a_db}), '0);
  endtask

  task automatic t_bad();
    logic [31:0] bad [4];
    logic [3:0][VA-1:0] good = fill(11);
    bad[0] = w_narrow(2'd1, 3'd2, 3'd3) | 32'h1;
    bad[1] = w_narrow(2'd1, 3'd2, 3'd3) | 32'h20;
    bad[2] = w_wide(3'd2, 3'd3) | 32'h0040_0000;
    bad[3] = w_narrow(2'd1, 3'd2, 3'd3) ^ 32'h0100_0000;
    issue(w_narrow(2'd1, 3'd0, 3'd0), good);
    for (int i = 0; i < 4; i++) begin
      issue(bad[i], fill(20 + i));
      chk("R5", "undef on bad encoding", VA'(a_undef), 1);
      chk("R9", "done on undefined", VA'(a_done), 1);
      check_a("R9", good, 16);
    end
  endtask

  task automatic t_small();
    logic [3:0][VA-1:0] s = fill(31);
    issue(w_narrow(2'd2, 3'd0, 3'd1), s);
    chk("R7", "small undef size 32", VA'(b_undef), 0);
    chk("R3", "small res0", VA'(b0), VA'(expect_vec(s, 0, 32, VB)));
    chk("R3", "small res2", VA'(b2), VA'(expect_vec(s, 2, 32, VB)));
    issue(w_narrow(2'd3, 3'd0, 3'd1), fill(32));
    chk("R6", "small undef size 64", VA'(b_undef), 1);
    chk("R9", "small hold res1", VA'(b1), VA'(expect_vec(s, 1, 32, VB)));
    issue(w_wide(3'd0, 3'd1), fill(33));
    chk("R7", "small undef wide", VA'(b_undef), 1);
    chk("R9", "small hold res3", VA'(b3), VA'(expect_vec(s, 3, 32, VB)));
  endtask

  task automatic t_idle();
    logic [3:0][VA-1:0] s = fill(40);
    issue(w_narrow(2'd0, 3'd1, 3'd1), s);
    @(negedge clk);
    srcs = fill(41);
    instr = w_narrow(2'd3, 3'd1, 3'd1);
    repeat (3) @(negedge clk);
    check_a("R10", s, 8);
    chk("R10", "no done while idle", VA'(a_done), 0);
  endtask

  task automatic t_b2b();
    logic [3:0][VA-1:0] s1 = fill(50);
    logic [3:0][VA-1:0] s2 = fill(51);
    @(negedge clk);
    instr = w_narrow(2'd2, 3'd0, 3'd0);
    srcs = s1;
    in_valid = 1'b1;
    @(negedge clk);
    instr = w_narrow(2'd2, 3'd0, 3'd0) | 32'h1;
    srcs = s2;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9", "b2b undef raised", VA'(a_undef), 1);
    chk("R8", "b2b done held", VA'(a_done), 1);
    check_a("R9", s1, 32);
    @(negedge clk);
    instr = w_narrow(2'd1, 3'd0, 3'd0);
    srcs = s1;
    in_valid = 1'b1;
    @(negedge clk);
    instr = w_narrow(2'd3, 3'd0, 3'd0);
    srcs = s2;
    check_a("R8", s1, 16);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8", "b2b legal done", VA'(a_done), 1);
    check_a("R1 R3", s2, 64);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_sizes();
    t_bases();
    t_bad();
    t_small();
    t_idle();
    t_b2b();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule